// File: doc/BRIEF.md
# Eight-Input Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output toward a processor and hands back a vector type during a two-pulse acknowledge handshake. Each request is captured in a request register, either on a rising edge (the default) or for as long as the line stays high (level mode). A per-input mask byte keeps captured requests from being forwarded. A fixed-priority resolver picks the lowest-numbered enabled request, and forwards it only if it outranks every input currently in service. The processor's active-low acknowledge strobe is sampled on the clock.

On the first acknowledge pulse the winning input is frozen, its in-service bit is set and its request bit is cleared. On the second pulse the vector type appears on an 8-bit bus with a drive-enable. The vector type is the five configured upper bits followed by the 3-bit input number. A non-specific end-of-interrupt command clears the highest-priority in-service bit.

The handshake state machine has four states: `ACK_IDLE`, `ACK_FIRST`, `ACK_GAP` and `ACK_SECOND`. A sampled falling edge of the strobe moves `ACK_IDLE` to `ACK_FIRST`, which freezes the winner. A rising edge moves `ACK_FIRST` to `ACK_GAP`. A falling edge moves `ACK_GAP` to `ACK_SECOND`, where the vector is driven. A rising edge moves `ACK_SECOND` back to `ACK_IDLE`. In every other case the state holds.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_out` is 0 and `vec_oe` is 0, with no request and no in-service bit set.
- R2: In edge mode (`level_mode`=0), a 0-to-1 change on `irq_lines[i]` latches request i until it is acknowledged. A line held high after acknowledge and end-of-interrupt raises no new request.
- R3: In level mode (`level_mode`=1), request i follows `irq_lines[i]`. A line that drops before acknowledge withdraws its request. A line still high after end-of-interrupt requests again.
- R4: `mask_bits[i]`=1 stops request i from being forwarded, and 0 enables it. A request latched while masked is forwarded once its mask bit is cleared.
- R5: Among enabled pending requests, the lowest input number wins. Input 0 is the highest priority and input 7 is the lowest.
- R6: The clock edge that samples the falling edge of the first acknowledge pulse freezes the winner, sets its in-service bit and clears its request bit. With no other eligible request, `irq_out` then falls.
- R7: `vec_oe` is 1 only in the cycles of the second acknowledge pulse. While it is 1, `vec_bus` = {`vec_hi`[4:0], input number[2:0]}. Otherwise `vec_bus` is 0.
- R8: A pending request is forwarded only if its number is strictly lower than every set in-service bit. Equal and lower-priority requests wait, and higher-priority requests nest.
- R9: A one-cycle `eoi_cmd` clears only the lowest-numbered set in-service bit.
- R10: An acknowledge that arrives with no request forwarded yields input number 7 in the vector and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 8 | Request lines, bit i is input i |
| ack_n | input | 1 | Active-low acknowledge strobe, synchronous to clk |
| mask_bits | input | 8 | 1 masks input i |
| vec_hi | input | 5 | Upper five bits of every vector type |
| level_mode | input | 1 | 1 selects level capture, 0 selects edge capture |
| eoi_cmd | input | 1 | One-cycle non-specific end-of-interrupt command |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_bus | output | 8 | Vector type, valid while vec_oe is 1 |
| vec_oe | output | 1 | Drive enable for vec_bus |

## Verification
The assertions assume that `ack_n` and `irq_lines` are already synchronous to `clk`. They also assume that each strobe level lasts at least one clock, so that the sampled edges match the real pulses, and that `eoi_cmd` is a single-cycle pulse. The stimulus changes every input one time unit after a rising clock edge and holds each acknowledge level for exactly one clock. It issues one end-of-interrupt only after a handshake completes, so that every service is closed before the next scenario begins.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_state_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] lines,
    input  logic               level_mode,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_IRQ-1:0] req
);
    logic [NUM_IRQ-1:0] prev_lines;
    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] req_nxt;

    // prev resets high so a line already high at reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lines <= '1;
        else        prev_lines <= lines;
    end

    assign rise = lines & ~prev_lines;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        always_comb begin
            if (level_mode) req_nxt[i] = lines[i];
            else            req_nxt[i] = req[i] | rise[i];
            if (clr_en && (clr_idx == IDX_W'(i))) req_nxt[i] = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req[i] <= 1'b0;
            else        req[i] <= req_nxt[i];
        end
    end

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !clr_en) |=> (req == $past(lines)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] req,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] isr,
    output logic               fwd_valid,
    output logic [IDX_W-1:0]   fwd_idx
);
    logic [NUM_IRQ-1:0] cand;
    logic [IDX_W-1:0]   isr_idx;
    logic               isr_any;

    assign cand    = req & ~mask;
    assign isr_any = |isr;

    always_comb begin
        fwd_idx = IDX_W'(NUM_IRQ - 1);
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (cand[i]) fwd_idx = IDX_W'(i);
        end
    end

    always_comb begin
        isr_idx = IDX_W'(NUM_IRQ - 1);
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (isr[i]) isr_idx = IDX_W'(i);
        end
    end

    assign fwd_valid = (|cand) && (!isr_any || (fwd_idx < isr_idx));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int HI_W   = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_n,
    input  logic               eoi_cmd,
    input  logic               fwd_valid,
    input  logic [IDX_W-1:0]   fwd_idx,
    input  logic [HI_W-1:0]    vec_hi,
    output logic [NUM_IRQ-1:0] isr,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic [VEC_W-1:0]   vec_bus,
    output logic               vec_oe
);
    ack_state_e         state, state_nxt;
    logic               ack_prev;
    logic               ack_fall, ack_rise;
    logic               take;
    logic [IDX_W-1:0]   frozen;
    logic [NUM_IRQ-1:0] eoi_bit, set_bit;

    assign ack_fall = ack_prev & ~ack_n;
    assign ack_rise = ~ack_prev & ack_n;
    assign take     = (state == ACK_IDLE) && ack_fall;
    assign clr_en   = take && fwd_valid;
    assign clr_idx  = fwd_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ACK_IDLE;
            ack_prev <= 1'b1;
        end else begin
            state    <= state_nxt;
            ack_prev <= ack_n;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ACK_IDLE:   if (ack_fall) state_nxt = ACK_FIRST;
            ACK_FIRST:  if (ack_rise) state_nxt = ACK_GAP;
            ACK_GAP:    if (ack_fall) state_nxt = ACK_SECOND;
            ACK_SECOND: if (ack_rise) state_nxt = ACK_IDLE;
        endcase
    end

    // frozen winner and in-service register
    assign eoi_bit = eoi_cmd ? (isr & ~(isr - NUM_IRQ'(1))) : '0;
    assign set_bit = clr_en ? (NUM_IRQ'(1) << fwd_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frozen <= '0;
            isr    <= '0;
        end else begin
            if (take) frozen <= fwd_valid ? fwd_idx : IDX_W'(NUM_IRQ - 1);
            isr <= (isr & ~eoi_bit) | set_bit;
        end
    end

    // outputs
    always_comb begin
        vec_oe  = 1'b0;
        vec_bus = '0;
        unique case (state)
            ACK_SECOND: begin
                vec_oe  = 1'b1;
                vec_bus = {vec_hi, frozen};
            end
            ACK_IDLE, ACK_FIRST, ACK_GAP: ;
        endcase
    end

    // R6
    isr_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !eoi_cmd) |=> ($countones(isr) == $past($countones(isr)) + 1));
    // R9
    eoi_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && (isr != '0) && !clr_en) |=> ($countones(isr) == $past($countones(isr)) - 1));
    // R7
    vec_oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> ($past(ack_n) == 1'b0));
    // R10
    spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fwd_valid && !eoi_cmd) |=> $stable(isr));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_IRQ = 8,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int HI_W   = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               ack_n,
    input  logic [NUM_IRQ-1:0] mask_bits,
    input  logic [HI_W-1:0]    vec_hi,
    input  logic               level_mode,
    input  logic               eoi_cmd,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_bus,
    output logic               vec_oe
);
    logic [NUM_IRQ-1:0] req, isr;
    logic               fwd_valid, clr_en;
    logic [IDX_W-1:0]   fwd_idx, clr_idx;

    irq_req_latch #(.NUM_IRQ(NUM_IRQ)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .level_mode(level_mode),
        .clr_en(clr_en), .clr_idx(clr_idx), .req(req)
    );

    irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .req(req), .mask(mask_bits), .isr(isr),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx)
    );

    irq_ack_fsm #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .eoi_cmd(eoi_cmd),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .vec_hi(vec_hi),
        .isr(isr), .clr_en(clr_en), .clr_idx(clr_idx),
        .vec_bus(vec_bus), .vec_oe(vec_oe)
    );

    assign irq_out = fwd_valid;

    // R8
    nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((isr & ((NUM_IRQ'(2) << fwd_idx) - NUM_IRQ'(1))) == '0));
    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !mask_bits[fwd_idx]);
    // R6
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !req[$past(clr_idx)]);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!irq_out && !vec_oe));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       ack_n = 1'b1;
    logic [7:0] mask_bits = '0;
    logic [4:0] vec_hi = 5'b01000;
    logic       level_mode = 1'b0;
    logic       eoi_cmd = 1'b0;
    logic       irq_out;
    logic [7:0] vec_bus;
    logic       vec_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ack_n(ack_n),
        .mask_bits(mask_bits), .vec_hi(vec_hi), .level_mode(level_mode),
        .eoi_cmd(eoi_cmd), .irq_out(irq_out), .vec_bus(vec_bus), .vec_oe(vec_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ack_first();
        ack_n = 1'b0; step();
        ack_n = 1'b1; step();
        chk("R7 no drive between pulses", {7'd0, vec_oe}, 8'd0);
    endtask

    task automatic ack_second(input logic [7:0] exp_vec, input string tag);
        ack_n = 1'b0; step();
        chk({tag, " vec_oe"}, {7'd0, vec_oe}, 8'd1);
        chk(tag, vec_bus, exp_vec);
        ack_n = 1'b1; step();
        chk("R7 drive released", {7'd0, vec_oe}, 8'd0);
    endtask

    task automatic eoi();
        eoi_cmd = 1'b1; step();
        eoi_cmd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq_out", {7'd0, irq_out}, 8'd0);
        chk("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
    endtask

    task automatic t_edge();
        irq_lines[3] = 1'b1; step();
        chk("R2 edge latched", {7'd0, irq_out}, 8'd1);
        ack_first();
        chk("R6 irq_out drops", {7'd0, irq_out}, 8'd0);
        ack_second(8'h43, "R7 vector input 3");
        eoi(); step();
        chk("R2 held line no re-request", {7'd0, irq_out}, 8'd0);
        irq_lines[3] = 1'b0; step();
    endtask

    task automatic t_prio();
        irq_lines[5] = 1'b1; irq_lines[2] = 1'b1; step();
        chk("R5 request seen", {7'd0, irq_out}, 8'd1);
        ack_first();
        chk("R8 lower waits", {7'd0, irq_out}, 8'd0);
        ack_second(8'h42, "R5 winner input 2");
        eoi(); step();
        chk("R9 eoi reopens", {7'd0, irq_out}, 8'd1);
        ack_first();
        ack_second(8'h45, "R5 next input 5");
        eoi();
        irq_lines = '0; step();
    endtask

    task automatic t_nest();
        irq_lines[4] = 1'b1; step();
        ack_first(); ack_second(8'h44, "R8 input 4");
        irq_lines[6] = 1'b1; step();
        chk("R8 lower blocked", {7'd0, irq_out}, 8'd0);
        irq_lines[1] = 1'b1; step();
        chk("R8 higher nests", {7'd0, irq_out}, 8'd1);
        ack_first(); ack_second(8'h41, "R8 nested input 1");
        eoi(); step();
        chk("R9 only top bit cleared", {7'd0, irq_out}, 8'd0);
        eoi(); step();
        chk("R9 second eoi", {7'd0, irq_out}, 8'd1);
        ack_first(); ack_second(8'h46, "R8 input 6");
        eoi();
        irq_lines = '0; step();
    endtask

    task automatic t_mask();
        mask_bits[0] = 1'b1;
        irq_lines[0] = 1'b1; step();
        chk("R4 masked", {7'd0, irq_out}, 8'd0);
        mask_bits[0] = 1'b0; #1;
        chk("R4 unmasked forwards", {7'd0, irq_out}, 8'd1);
        ack_first(); ack_second(8'h40, "R4 input 0");
        eoi();
        irq_lines = '0; step();
    endtask

    task automatic t_level();
        level_mode = 1'b1;
        irq_lines[7] = 1'b1; step();
        chk("R3 level high", {7'd0, irq_out}, 8'd1);
        irq_lines[7] = 1'b0; step();
        chk("R3 level withdrawn", {7'd0, irq_out}, 8'd0);
        irq_lines[7] = 1'b1; step();
        ack_first(); ack_second(8'h47, "R3 input 7");
        eoi(); step();
        chk("R3 still high re-requests", {7'd0, irq_out}, 8'd1);
        irq_lines[7] = 1'b0; step();
        chk("R3 dropped", {7'd0, irq_out}, 8'd0);
        level_mode = 1'b0; step();
    endtask

    task automatic t_spurious();
        vec_hi = 5'b10101;
        ack_first(); ack_second(8'hAF, "R10 default vector");
        irq_lines[7] = 1'b1; step();
        chk("R10 no in-service set", {7'd0, irq_out}, 8'd1);
        ack_first(); ack_second(8'hAF, "R10 real input 7");
        eoi();
        irq_lines = '0; step();
        vec_hi = 5'b01000;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_edge();
        t_prio();
        t_nest();
        t_mask();
        t_level();
        t_spurious();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule